// File: doc/BRIEF.md
# Fixed-Page Hardware Stack Controller

This block owns the stack pointer of a 256-byte hardware stack that sits in one fixed page of memory (addresses 0x0100 to 0x01FF). The pointer always names the next free byte. A command port asks for one of six operations: store one byte, fetch one byte, store a two-byte program counter (for a subroutine call), fetch it back (for the return), overwrite the pointer from an index register value, or copy the pointer out to an index register. The block turns each command into single-cycle memory accesses with a full 16-bit address and a read or write strobe. It also returns the fetched data, or the pointer value and its sign and zero flags.

The surrounding core issues a command with `cmd_valid` for one cycle and waits for `done`. The memory is outside the block and answers reads combinationally within the access cycle. Storing writes at the current pointer and then moves the pointer down. Fetching moves the pointer up and reads at the new position in the same cycle. The pointer wraps modulo 256 and gives no overflow indication.

Top module: `stack_page_ctrl`

## Requirements
- R1: After reset the pointer is 0xFF, and `done`, `mem_we` and `mem_re` are low.
- R2: Every memory access drives 0x01 on the upper address byte; the lower byte comes from the pointer.
- R3: A byte store (cmd_op 0) writes `cmd_data[7:0]` at 0x0100+pointer in the first cycle after acceptance, then decrements the pointer.
- R4: A byte fetch (cmd_op 1) increments the pointer and reads 0x0100+new pointer in the same single cycle; `result` is {0x00, byte read}.
- R5: A word store (cmd_op 2) writes `cmd_data[15:8]` at the pointer, then `cmd_data[7:0]` at pointer-1, in two consecutive cycles, leaving the pointer lowered by 2.
- R6: A word fetch (cmd_op 3) reads the low byte at pointer+1, then the high byte at pointer+2, in two consecutive cycles; `result` is {high, low} and the pointer rises by 2.
- R7: Loading from the index value (cmd_op 4) sets the pointer to `cmd_data[7:0]`, makes no memory access, and does not pulse `nz_we`.
- R8: Reading to the index value (cmd_op 5) makes no memory access. It returns `result` = {0x00, pointer}, pulses `nz_we` with `done`, and gives `nz_n` = bit 7 and `nz_z` = (pointer == 0).
- R9: The pointer wraps modulo 256: decrementing 0x00 yields 0xFF and incrementing 0xFF yields 0x00.
- R10: `done` is high for exactly one cycle, in the cycle after the last access (or the single internal cycle) of each accepted command.
- R11: A command presented while another is in progress, or with cmd_op 6 or 7, is ignored: no access, no `done`, pointer unchanged.
- R12: `mem_we` and `mem_re` are never high together, and neither is high unless a store or fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when idle |
| cmd_op | input | 3 | Operation code 0..5 |
| cmd_data | input | 16 | Byte in [7:0], word to store, or new pointer in [7:0] |
| result | output | 16 | Fetched byte/word or pointer value, valid with done |
| nz_we | output | 1 | Flag update strobe for pointer readout |
| nz_n | output | 1 | Sign of the pointer readout |
| nz_z | output | 1 | Zero indication of the pointer readout |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address, page 0x01 |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the access cycle |

## Verification
A long random mix of all six operations runs against a bench-side model of the pointer and the page contents. It separates write-then-decrement from decrement-then-write, since each order leaves its bytes at different addresses that later fetches expose. It also separates the high-first store order from the low-first fetch order, because each word fetch must return the word stored before it. Directed runs at pointer 0x00 and 0xFF show the modulo-256 wrap inside a word access. Pointer readouts of 0x00 and 0x80 tell the zero flag apart from the sign flag. Commands held active during a busy word store, and the unused codes 6 and 7, show whether stray requests reach the pointer.

// File: rtl/stk_pkg.sv
// Shared types for the fixed-page stack controller.
// Assumes the command field is 3 bits wide; codes above 5 are unused.
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH_B = 3'd0,
        OP_PULL_B = 3'd1,
        OP_PUSH_W = 3'd2,
        OP_PULL_W = 3'd3,
        OP_SET_SP = 3'd4,
        OP_GET_SP = 3'd5
    } stk_op_e;

    typedef struct packed {
        logic dec;
        logic inc;
        logic load;
    } ptr_ctl_t;

    // True for the six defined operation codes.
    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

endpackage

// File: rtl/stk_ptr.sv
// Stack pointer register with load, decrement and increment.
// Assumes at most one control bit is set per cycle; load wins, then dec, then inc.
// Arithmetic wraps modulo 2**PTR_W.
module stk_ptr #(
    parameter int              PTR_W     = 8,
    parameter logic [PTR_W-1:0] RESET_VAL = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  stk_pkg::ptr_ctl_t   ctl,
    input  logic [PTR_W-1:0]    load_val,
    output logic [PTR_W-1:0]    sp,
    output logic [PTR_W-1:0]    sp_up
);

    // Pointer state update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= RESET_VAL;
        else if (ctl.load)
            sp <= load_val;
        else if (ctl.dec)
            sp <= sp - 1'b1;
        else if (ctl.inc)
            sp <= sp + 1'b1;
    end

    // Pre-incremented pointer used as the fetch address.
    always_comb sp_up = sp + 1'b1;

endmodule

// File: rtl/stk_seq.sv
// Command sequencer: accepts one command when idle, steps through one or two
// single-cycle memory beats, steers the pointer and captures the result.
// Assumes memory read data is valid combinationally in the access cycle.
module stk_seq #(
    parameter int DATA_W = 8,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [WORD_W-1:0]   cmd_data,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [DATA_W-1:0]   sp,
    output stk_pkg::ptr_ctl_t   ctl,
    output logic [DATA_W-1:0]   load_val,
    output logic                mem_we,
    output logic                mem_re,
    output logic                up_sel,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                done,
    output logic                nz_we,
    output logic [WORD_W-1:0]   result
);
    import stk_pkg::*;

    logic              busy_q;
    stk_op_e           op_q;
    logic [WORD_W-1:0] data_q;
    logic              beat_q;
    logic              last;
    logic              accept;

    always_comb accept = cmd_valid && !busy_q && op_known(cmd_op);
    always_comb load_val = data_q[DATA_W-1:0];

    // Per-beat strobes, pointer steering and end-of-command detection.
    always_comb begin
        ctl       = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        up_sel    = 1'b0;
        mem_wdata = data_q[DATA_W-1:0];
        last      = 1'b0;
        if (busy_q) begin
            case (op_q)
                OP_PUSH_B: begin
                    mem_we  = 1'b1;
                    ctl.dec = 1'b1;
                    last    = 1'b1;
                end
                OP_PUSH_W: begin
                    mem_we    = 1'b1;
                    ctl.dec   = 1'b1;
                    mem_wdata = beat_q ? data_q[DATA_W-1:0] : data_q[WORD_W-1:DATA_W];
                    last      = beat_q;
                end
                OP_PULL_B: begin
                    mem_re  = 1'b1;
                    up_sel  = 1'b1;
                    ctl.inc = 1'b1;
                    last    = 1'b1;
                end
                OP_PULL_W: begin
                    mem_re  = 1'b1;
                    up_sel  = 1'b1;
                    ctl.inc = 1'b1;
                    last    = beat_q;
                end
                OP_SET_SP: begin
                    ctl.load = 1'b1;
                    last     = 1'b1;
                end
                default: last = 1'b1;
            endcase
        end
    end

    // Command acceptance, beat counting and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= OP_PUSH_B;
            data_q <= '0;
            beat_q <= 1'b0;
            done   <= 1'b0;
            nz_we  <= 1'b0;
        end else begin
            done  <= busy_q && last;
            nz_we <= busy_q && last && (op_q == OP_GET_SP);
            if (!busy_q) begin
                if (accept) begin
                    busy_q <= 1'b1;
                    op_q   <= stk_op_e'(cmd_op);
                    data_q <= cmd_data;
                    beat_q <= 1'b0;
                end
            end else begin
                beat_q <= 1'b1;
                if (last)
                    busy_q <= 1'b0;
            end
        end
    end

    // Result capture from memory reads or from the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (busy_q) begin
            case (op_q)
                OP_PULL_B: result <= {{DATA_W{1'b0}}, mem_rdata};
                OP_PULL_W: begin
                    if (beat_q)
                        result[WORD_W-1:DATA_W] <= mem_rdata;
                    else
                        result[DATA_W-1:0] <= mem_rdata;
                end
                OP_GET_SP: result <= {{DATA_W{1'b0}}, sp};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stack_page_ctrl.sv
// Fixed-page stack controller top: joins the sequencer and the pointer and
// forms the page address. Assumes an external byte memory with one-cycle
// combinational reads; the pointer names the next free byte.
module stack_page_ctrl #(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] PAGE_HI   = 8'h01,
    parameter logic [DATA_W-1:0] RESET_PTR = 8'hFF,
    localparam int              WORD_W    = 2 * DATA_W,
    localparam int              ADDR_W    = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [WORD_W-1:0]   cmd_data,
    output logic [WORD_W-1:0]   result,
    output logic                nz_we,
    output logic                nz_n,
    output logic                nz_z,
    output logic                done,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);

    stk_pkg::ptr_ctl_t  ctl;
    logic [DATA_W-1:0]  load_val;
    logic [DATA_W-1:0]  sp_q;
    logic [DATA_W-1:0]  sp_up;
    logic               up_sel;

    stk_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .mem_rdata (mem_rdata),
        .sp        (sp_q),
        .ctl       (ctl),
        .load_val  (load_val),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .up_sel    (up_sel),
        .mem_wdata (mem_wdata),
        .done      (done),
        .nz_we     (nz_we),
        .result    (result)
    );

    stk_ptr #(.PTR_W(DATA_W), .RESET_VAL(RESET_PTR)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .load_val (load_val),
        .sp       (sp_q),
        .sp_up    (sp_up)
    );

    // Page address: fixed upper byte, pointer or pre-incremented pointer below.
    always_comb mem_addr = {PAGE_HI, (up_sel ? sp_up : sp_q)};

    // Flags derived from the pointer readout held in the result register.
    always_comb begin
        nz_n = result[DATA_W-1];
        nz_z = (result[DATA_W-1:0] == '0);
    end

endmodule

// File: rtl/stack_page_ctrl_chk.sv
// Property checker for the stack controller, bound to the top.
// Assumes it sees the top's pointer register through the bind connection.
module stack_page_ctrl_chk #(
    parameter int               DATA_W  = 8,
    parameter logic [DATA_W-1:0] PAGE_HI = 8'h01,
    localparam int              ADDR_W  = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              nz_we,
    input logic [DATA_W-1:0] sp
);

    a_r2_fixed_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:DATA_W] == PAGE_HI));

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r3_write_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(mem_addr[DATA_W-1:0]) - 1'b1));

    a_r4_inc_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == $past(mem_addr[DATA_W-1:0])));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        nz_we |-> done);

endmodule

bind stack_page_ctrl stack_page_ctrl_chk #(.DATA_W(DATA_W), .PAGE_HI(PAGE_HI)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .done     (done),
    .nz_we    (nz_we),
    .sp       (sp_q)
);

// File: tb/stack_page_ctrl_test.sv
`timescale 1ns/1ps
module stack_page_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'h0;
    logic [15:0] result;
    logic        nz_we, nz_n, nz_z, done;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  bmem [0:255];
    logic [7:0]  mdl  [0:255];
    logic [7:0]  exp_sp;
    int          errs = 0;
    int          checks = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    stack_page_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .result(result), .nz_we(nz_we), .nz_n(nz_n),
        .nz_z(nz_z), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Issue one command and check every cycle until its done pulse.
    task automatic run(input int op, input logic [15:0] d, input string tag);
        string rq;
        int n;
        int ecyc;
        bit ew [2];
        logic [15:0] ea [2];
        logic [7:0] ed [2];
        logic [15:0] eres;
        rq = (tag.len() != 0) ? tag : req_of(op);
        n = 0; eres = 16'h0;
        ew[0] = 0; ew[1] = 0; ea[0] = 0; ea[1] = 0; ed[0] = 0; ed[1] = 0;
        case (op)
            0: begin
                ew[0] = 1; ea[0] = {8'h01, exp_sp}; ed[0] = d[7:0];
                mdl[exp_sp] = d[7:0]; exp_sp = exp_sp - 8'd1; n = 1;
            end
            2: begin
                ew[0] = 1; ea[0] = {8'h01, exp_sp}; ed[0] = d[15:8];
                mdl[exp_sp] = d[15:8]; exp_sp = exp_sp - 8'd1;
                ew[1] = 1; ea[1] = {8'h01, exp_sp}; ed[1] = d[7:0];
                mdl[exp_sp] = d[7:0]; exp_sp = exp_sp - 8'd1; n = 2;
            end
            1: begin
                exp_sp = exp_sp + 8'd1; ea[0] = {8'h01, exp_sp};
                eres = {8'h00, mdl[exp_sp]}; n = 1;
            end
            3: begin
                exp_sp = exp_sp + 8'd1; ea[0] = {8'h01, exp_sp}; eres[7:0] = mdl[exp_sp];
                exp_sp = exp_sp + 8'd1; ea[1] = {8'h01, exp_sp}; eres[15:8] = mdl[exp_sp];
                n = 2;
            end
            4: exp_sp = d[7:0];
            default: eres = {8'h00, exp_sp};
        endcase
        ecyc = (n == 0) ? 1 : n;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done before command", done, 0);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i <= ecyc; i++) begin
            if (i < ecyc) begin
                chk(done == 1'b0, "R10", "done during busy", done, 0);
                if (i < n) begin
                    chk(mem_we == ew[i] && mem_re == !ew[i], rq, "strobes (R12)",
                        {mem_we, mem_re}, {ew[i], !ew[i]});
                    chk(mem_addr == ea[i], rq, "address (R2)", mem_addr, ea[i]);
                    if (ew[i]) chk(mem_wdata == ed[i], rq, "write data", mem_wdata, ed[i]);
                end else begin
                    chk(!mem_we && !mem_re, rq, "no access", {mem_we, mem_re}, 0);
                end
                @(negedge clk);
            end else begin
                chk(done == 1'b1, "R10", "done pulse", done, 1);
                chk(!mem_we && !mem_re, "R12", "idle strobes", {mem_we, mem_re}, 0);
                chk(nz_we == (op == 5), rq, "nz_we", nz_we, (op == 5));
                if (op == 1 || op == 3 || op == 5)
                    chk(result == eres, rq, "result", result, eres);
                if (op == 5) begin
                    chk(nz_n == eres[7], rq, "nz_n", nz_n, eres[7]);
                    chk(nz_z == (eres[7:0] == 8'h00), rq, "nz_z", nz_z, (eres[7:0] == 8'h00));
                end
            end
        end
    endtask

    // Quiet-window check used by the ignore tests (R11).
    task automatic quiet(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(!done && !mem_we && !mem_re, "R11", "ignored command activity",
                {done, mem_we, mem_re}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17C3E1));
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            bmem[i] = v;
            mdl[i] = v;
        end
        exp_sp = 8'hFF;
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!done && !mem_we && !mem_re, "R1", "outputs in reset", {done, mem_we, mem_re}, 0);
        @(negedge clk) rst_n = 1'b1;
        chk(!done && !mem_we && !mem_re, "R1", "outputs after reset", {done, mem_we, mem_re}, 0);
        run(5, 16'h0, "R1");

        // Directed: call/return pair and flag corners.
        run(2, 16'hBEEF, "");
        run(0, 16'h0042, "");
        run(1, 16'h0, "");
        run(3, 16'h0, "");
        run(4, 16'h0000, "");
        run(5, 16'h0, "R8");
        run(4, 16'h0080, "");
        run(5, 16'h0, "R8");

        // R9: wrap at both ends, inside word accesses.
        run(4, 16'h0000, "R9");
        run(0, 16'h0011, "R9");
        run(1, 16'h0, "R9");
        run(2, 16'hA55A, "R9");
        run(5, 16'h0, "R9");
        run(3, 16'h0, "R9");
        run(4, 16'h00FF, "R9");
        run(3, 16'h0, "R9");
        run(5, 16'h0, "R9");

        // R11: command held during a busy word store.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_data = 16'h1234;
        @(negedge clk);
        cmd_op = 3'd5;
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R11", "done of busy store", done, 1);
        cmd_valid = 1'b0;
        mdl[exp_sp] = 8'h12; exp_sp = exp_sp - 8'd1;
        mdl[exp_sp] = 8'h34; exp_sp = exp_sp - 8'd1;
        quiet(3);
        run(5, 16'h0, "R11");

        // R11: unused operation codes.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 16'h0033;
        @(negedge clk);
        chk(!done && !mem_we && !mem_re, "R11", "code 6", {done, mem_we, mem_re}, 0);
        cmd_op = 3'd7;
        @(negedge clk);
        cmd_valid = 1'b0;
        quiet(3);
        run(5, 16'h0, "R11");
        run(3, 16'h0, "R11");

        // Random mix.
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [15:0] d;
            op = int'($urandom % 6);
            d = 16'($urandom);
            if (op == 4 && ($urandom % 3) == 0) begin
                case ($urandom % 4)
                    0: d[7:0] = 8'h00;
                    1: d[7:0] = 8'hFF;
                    2: d[7:0] = 8'h80;
                    default: d[7:0] = 8'h7F;
                endcase
            end
            run(op, d, "");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule